// File: doc/BRIEF.md
# Low-Latency DRAM Power-Up Initialization Sequencer

This block owns the command bus of a multi-bank low-latency DRAM from reset until the memory may accept normal traffic. It holds the bus in a deselected (NOP) state until an external "supplies and clock stable" input goes high. It then waits out a minimum NOP idle window whose length comes from a clock-frequency parameter. After that it fires a back-to-back burst of mode-register writes, where the leading writes are dummies with an all-zero address and the last one carries the programmed mode value. It waits the mode-register cycle time and then auto-refreshes every bank exactly once. It pads the end with NOP cycles and only then raises a sticky init-done flag.

Every output is registered. The bus is plain control: a command slot is issued every clock and there is no handshake. Refresh order across banks is a stride permutation set by a parameter. Each bank has its own row-cycle timer. A refresh is held back while that timer runs, and init-done is held back until every bank timer has expired.

Top module: `lldram_init_seq`

## Requirements
- R1: While reset is high or `supply_ok` is low, the bus carries only NOP slots. A NOP slot is `cs_n`=1, `cmd`=2'b00, `addr`=0 and `bank`=0. `cs_n` is low only for a mode-register write (`cmd`=2'b01) or an auto-refresh (`cmd`=2'b10).
- R2: After `supply_ok` rises, at least CLK_MHZ*IDLE_US NOP slots appear before the first mode-register write. The first write follows no more than two slots beyond that minimum.
- R3: Exactly MRS_DUMMIES+1 mode-register writes are issued, on consecutive cycles, as a single unbroken run.
- R4: Each dummy mode-register write drives `addr`=0 and `bank`=0. The final write of the run drives `addr`=MODE_VALUE.
- R5: Between the final mode-register write and the first auto-refresh there are at least T_MRSC NOP slots, and at most T_MRSC+1.
- R6: Exactly NUM_BANKS auto-refreshes are issued, one to each bank number 0..NUM_BANKS-1 on `bank`. No bank is refreshed twice.
- R7: No auto-refresh appears before the mode-register run, and no mode-register write appears after any auto-refresh.
- R8: `init_done` rises after at least max(PAD_NOPS, T_RC) NOP slots following the last auto-refresh, and at most one slot later.
- R9: Once `init_done` is high it stays high until reset, and the bus carries only NOP slots while it is high.
- R10: Reset at any point returns the outputs to the NOP slot with `init_done`=0 and restarts the whole sequence from the stability wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supplies and clock reported stable |
| cs_n | output | 1 | Chip select, active low |
| cmd | output | 2 | Command code: 00 NOP, 01 mode-register write, 10 auto-refresh |
| addr | output | ADDR_W | Address bus (mode value on the final mode-register write) |
| bank | output | BANK_W | Bank address for auto-refresh |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions assume that `supply_ok`, once high, stays high until the next reset. A falling edge outside reset is not a case the sequence defines, so the idle-window and no-command properties lean on that assumption. The stimulus keeps to it: each run holds `supply_ok` low for a random number of cycles after reset and then raises it for good. Reset is the only disturbance, and it is injected at a random cycle, either mid-sequence or after completion. A second instance with a short pad and a long row-cycle time makes the bank timers, not the pad, decide when `init_done` rises.

// File: rtl/lldram_init_pkg.sv
package lldram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_MRS  = 2'b01,
    CMD_AREF = 2'b10
  } cmd_e;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_IDLE,
    PH_MRS,
    PH_MRSC,
    PH_REF,
    PH_PAD,
    PH_READY
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lldram_init_timer.sv
module lldram_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lldram_bank_guard.sv
module lldram_bank_guard #(
  parameter int NUM_BANKS = 8,
  parameter int T_RC      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] start,
  output logic [NUM_BANKS-1:0] busy
);
  localparam int RC_W = $clog2(T_RC + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [RC_W-1:0] rc_cnt;
    always_ff @(posedge clk) begin
      if (rst)                 rc_cnt <= '0;
      else if (start[b])       rc_cnt <= RC_W'(T_RC - 1);
      else if (rc_cnt != '0)   rc_cnt <= rc_cnt - 1'b1;
    end
    assign busy[b] = (rc_cnt != '0);
  end
endmodule

// File: rtl/lldram_init_fsm.sv
module lldram_init_fsm
  import lldram_init_pkg::*;
#(
  parameter int IDLE_CYC   = 10000,
  parameter int MRS_TOTAL  = 3,
  parameter int T_MRSC     = 6,
  parameter int NUM_BANKS  = 8,
  parameter int REF_STRIDE = 3,
  parameter int PAD_NOPS   = 1024,
  parameter int ADDR_W     = 20,
  parameter int BANK_W     = 3,
  parameter int CNT_W      = 16,
  parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 supply_ok,
  input  logic                 tmr_zero,
  input  logic [NUM_BANKS-1:0] bank_busy,
  output logic                 tmr_load,
  output logic [CNT_W-1:0]     tmr_val,
  output cmd_e                 op,
  output logic [ADDR_W-1:0]    op_addr,
  output logic [BANK_W-1:0]    op_bank,
  output logic [NUM_BANKS-1:0] ref_start,
  output logic                 done_next
);
  phase_e            phase, phase_nx;
  logic [BANK_W-1:0] ref_idx, ref_idx_nx;
  logic [BANK_W-1:0] bank_sel;

  assign bank_sel = BANK_W'((int'(ref_idx) * REF_STRIDE) % NUM_BANKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_WAIT;
      ref_idx <= '0;
    end else begin
      phase   <= phase_nx;
      ref_idx <= ref_idx_nx;
    end
  end

  always_comb begin
    phase_nx   = phase;
    ref_idx_nx = ref_idx;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    op         = CMD_NOP;
    op_addr    = '0;
    op_bank    = '0;
    ref_start  = '0;
    done_next  = 1'b0;
    unique case (phase)
      PH_WAIT: begin
        ref_idx_nx = '0;
        if (supply_ok) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(IDLE_CYC - 1);
          phase_nx = PH_IDLE;
        end
      end
      PH_IDLE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(MRS_TOTAL - 1);
          phase_nx = PH_MRS;
        end
      end
      PH_MRS: begin
        op = CMD_MRS;
        if (tmr_zero) begin
          op_addr  = MODE_VALUE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_MRSC - 1);
          phase_nx = PH_MRSC;
        end
      end
      PH_MRSC: begin
        if (tmr_zero) phase_nx = PH_REF;
      end
      PH_REF: begin
        if (!bank_busy[bank_sel]) begin
          op                  = CMD_AREF;
          op_bank             = bank_sel;
          ref_start[bank_sel] = 1'b1;
          ref_idx_nx          = ref_idx + 1'b1;
          if (ref_idx == BANK_W'(NUM_BANKS - 1)) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PAD_NOPS - 1);
            phase_nx = PH_PAD;
          end
        end
      end
      PH_PAD: begin
        if (tmr_zero && (bank_busy == '0)) phase_nx = PH_READY;
      end
      PH_READY: done_next = 1'b1;
      default: phase_nx = PH_WAIT;
    endcase
  end
endmodule

// File: rtl/lldram_cmd_reg.sv
module lldram_cmd_reg
  import lldram_init_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [BANK_W-1:0] op_bank,
  input  logic              done_next,
  output logic              cs_n,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              init_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n      <= 1'b1;
      cmd       <= CMD_NOP;
      addr      <= '0;
      bank      <= '0;
      init_done <= 1'b0;
    end else begin
      cs_n      <= (op == CMD_NOP);
      cmd       <= op;
      addr      <= op_addr;
      bank      <= (op == CMD_AREF) ? op_bank : '0;
      init_done <= done_next;
    end
  end
endmodule

// File: rtl/lldram_init_seq.sv
module lldram_init_seq
  import lldram_init_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int IDLE_US     = 200,
  parameter int MRS_DUMMIES = 2,
  parameter int T_MRSC      = 6,
  parameter int T_RC        = 8,
  parameter int NUM_BANKS   = 8,
  parameter int REF_STRIDE  = 3,
  parameter int PAD_NOPS    = 1024,
  parameter int ADDR_W      = 20,
  parameter logic [ADDR_W-1:0] MODE_VALUE = 20'h0A5C3,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  output logic              cs_n,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              init_done
);
  localparam int IDLE_CYC  = CLK_MHZ * IDLE_US;
  localparam int MRS_TOTAL = MRS_DUMMIES + 1;
  localparam int MAX_CNT   = imax(imax(IDLE_CYC, PAD_NOPS), imax(T_MRSC, MRS_TOTAL));
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  logic                 tmr_load, tmr_zero, done_next;
  logic [CNT_W-1:0]     tmr_val;
  logic [NUM_BANKS-1:0] bank_busy, ref_start;
  cmd_e                 op;
  logic [ADDR_W-1:0]    op_addr;
  logic [BANK_W-1:0]    op_bank;

  lldram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  lldram_bank_guard #(.NUM_BANKS(NUM_BANKS), .T_RC(T_RC)) u_guard (
    .clk(clk), .rst(rst), .start(ref_start), .busy(bank_busy)
  );

  lldram_init_fsm #(
    .IDLE_CYC(IDLE_CYC), .MRS_TOTAL(MRS_TOTAL), .T_MRSC(T_MRSC),
    .NUM_BANKS(NUM_BANKS), .REF_STRIDE(REF_STRIDE), .PAD_NOPS(PAD_NOPS),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W), .MODE_VALUE(MODE_VALUE)
  ) u_fsm (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .tmr_zero(tmr_zero),
    .bank_busy(bank_busy), .tmr_load(tmr_load), .tmr_val(tmr_val), .op(op),
    .op_addr(op_addr), .op_bank(op_bank), .ref_start(ref_start),
    .done_next(done_next)
  );

  lldram_cmd_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_out (
    .clk(clk), .rst(rst), .op(op), .op_addr(op_addr), .op_bank(op_bank),
    .done_next(done_next), .cs_n(cs_n), .cmd(cmd), .addr(addr), .bank(bank),
    .init_done(init_done)
  );
endmodule

// File: rtl/lldram_init_chk.sv
module lldram_init_chk #(
  parameter int IDLE_CYC  = 10000,
  parameter int T_MRSC    = 6,
  parameter int T_RC      = 8,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 20,
  parameter int BANK_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              supply_ok,
  input logic              cs_n,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              init_done
);
  logic                 any_cmd;
  logic [31:0]          idle_cnt, since_mrs, since_ref;
  logic [NUM_BANKS-1:0] refreshed;
  logic                 is_mrs, is_ref;

  assign is_mrs = !cs_n && (cmd == 2'b01);
  assign is_ref = !cs_n && (cmd == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      any_cmd   <= 1'b0;
      idle_cnt  <= '0;
      since_mrs <= '0;
      since_ref <= '0;
      refreshed <= '0;
    end else begin
      if (!cs_n) any_cmd <= 1'b1;
      if (supply_ok && !any_cmd) idle_cnt <= idle_cnt + 1;
      since_mrs <= is_mrs ? '0 : since_mrs + 1;
      since_ref <= is_ref ? '0 : since_ref + 1;
      if (is_ref) refreshed[bank] <= 1'b1;
    end
  end

  p_nop_unstable_r1: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |-> (cs_n && cmd == 2'b00));
  p_deselect_clean_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (cmd == 2'b00 && addr == '0 && bank == '0));
  p_idle_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !any_cmd) |-> (idle_cnt >= IDLE_CYC));
  p_dummy_low_r4: assert property (@(posedge clk) disable iff (rst)
    (is_mrs && addr != '0) |=> !is_mrs);
  p_mrsc_gap_r5: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (since_mrs >= T_MRSC));
  p_bank_once_r6: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> !refreshed[bank]);
  p_trc_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (since_ref >= T_RC - 1 && refreshed == '1));
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> cs_n);
endmodule

bind lldram_init_seq lldram_init_chk #(
  .IDLE_CYC(CLK_MHZ * IDLE_US), .T_MRSC(T_MRSC), .T_RC(T_RC),
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W($clog2(NUM_BANKS))
) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_n(cs_n), .cmd(cmd),
  .addr(addr), .bank(bank), .init_done(init_done)
);

// File: tb/sim_lldram_init_seq.sv
`timescale 1ns/1ps
module sim_lldram_init_seq;
  localparam logic [19:0] MODE = 20'h0A5C3;
  logic clk = 1'b0, rst = 1'b1, supply_ok = 1'b0;
  always #10 clk = ~clk;

  logic c0, c1, d0, d1;
  logic [1:0] k0, k1;
  logic [19:0] a0, a1;
  logic [2:0] b0, b1;

  lldram_init_seq u0 (.clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_n(c0),
    .cmd(k0), .addr(a0), .bank(b0), .init_done(d0));
  lldram_init_seq #(.IDLE_US(2), .T_RC(24), .PAD_NOPS(4), .REF_STRIDE(5)) u1 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_n(c1), .cmd(k1),
    .addr(a1), .bank(b1), .init_done(d1));

  int sel = 0, n_run = 0, n_fail = 0;
  logic m_cs, m_done;
  logic [1:0] m_cmd;
  logic [19:0] m_addr;
  logic [2:0] m_bank;
  always_comb begin
    m_cs   = sel ? c1 : c0;
    m_cmd  = sel ? k1 : k0;
    m_addr = sel ? a1 : a0;
    m_bank = sel ? b1 : b0;
    m_done = sel ? d1 : d0;
  end

  function automatic int exp_idle(input int s); return s ? 100 : 10000; endfunction
  function automatic int exp_tail(input int s); return s ? 24 : 1024; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int wait_cyc, input int reset_at);
    int cyc = 0, nops_pre = 0, mrs_run = 0, mrs_blocks = 0, gap = 0, ref_cnt = 0;
    int tail = 0, post = 0, gap_seen = 0;
    bit in_mrs = 0, prev_mrs = 0, dummy_bad = 0, order_bad = 0, unst_bad = 0;
    bit done_seen = 0, done_drop = 0, post_bad = 0, dup = 0, aborted = 0;
    logic [19:0] prev_addr = '0, last_addr = '0;
    logic [7:0] mask = '0;
    rst = 1'b1; supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(m_cs == 1'b1 && m_cmd == 2'b00 && m_addr == '0, "R10 reset bus", m_cs, 1);
    chk(m_done == 1'b0, "R10 reset done", m_done, 0);
    rst = 1'b0;
    forever begin
      @(negedge clk);
      if (done_seen) begin
        if (!m_done) done_drop = 1;
        if (!m_cs) post_bad = 1;
        post++;
        if (post == 8) break;
      end else if (m_done) begin
        done_seen = 1;
        chk(tail >= exp_tail(sel) && tail <= exp_tail(sel) + 1, "R8 tail NOPs",
            tail, exp_tail(sel));
      end else if (!m_cs) begin
        if (!supply_ok) unst_bad = 1;
        if (m_cmd == 2'b01) begin
          if (ref_cnt > 0) order_bad = 1;
          if (!in_mrs) mrs_blocks++;
          if (prev_mrs && prev_addr != '0) dummy_bad = 1;
          if (m_bank != '0) dummy_bad = 1;
          in_mrs = 1; mrs_run++; prev_addr = m_addr; last_addr = m_addr;
        end else if (m_cmd == 2'b10) begin
          if (mrs_run == 0) order_bad = 1;
          if (ref_cnt == 0) gap_seen = gap;
          if (mask[m_bank]) dup = 1;
          mask[m_bank] = 1'b1; ref_cnt++; tail = 0; in_mrs = 0;
        end
      end else begin
        if (m_cmd != 2'b00) unst_bad = 1;
        if (supply_ok && mrs_run == 0) nops_pre++;
        in_mrs = 0;
        if (mrs_run > 0 && ref_cnt == 0) gap++;
        if (ref_cnt > 0) tail++;
      end
      prev_mrs = !m_cs && m_cmd == 2'b01;
      cyc++;
      if (cyc == wait_cyc) supply_ok = 1'b1;
      if (reset_at != 0 && cyc == reset_at) begin aborted = 1; break; end
    end
    chk(!unst_bad, "R1 NOP while unstable", unst_bad, 0);
    if (aborted) begin
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(m_cs && m_cmd == 2'b00 && !m_done, "R10 mid-run reset", m_cs, 1);
      return;
    end
    chk(nops_pre >= exp_idle(sel) && nops_pre <= exp_idle(sel) + 2, "R2 idle NOPs",
        nops_pre, exp_idle(sel));
    chk(mrs_run == 3 && mrs_blocks == 1, "R3 MRS run", mrs_run, 3);
    chk(!dummy_bad, "R4 dummy addr low", dummy_bad, 0);
    chk(last_addr == MODE, "R4 mode value", int'(last_addr), int'(MODE));
    chk(gap_seen >= 6 && gap_seen <= 7, "R5 MRSC gap", gap_seen, 6);
    chk(ref_cnt == 8 && mask == 8'hFF && !dup, "R6 banks once", ref_cnt, 8);
    chk(!order_bad, "R7 order", order_bad, 0);
    chk(done_seen && !done_drop, "R9 done sticky", done_drop, 0);
    chk(!post_bad, "R9 quiet after done", post_bad, 0);
  endtask

  bit finished = 0;
  initial begin
    void'($urandom(32'd4242));
    sel = 0; run_seq(1 + int'($urandom_range(40)), 0);
    sel = 0; run_seq(2 + int'($urandom_range(20)), 5000 + int'($urandom_range(5200)));
    sel = 1; run_seq(1, 0);
    sel = 1; run_seq(3 + int'($urandom_range(30)), 120 + int'($urandom_range(30)));
    sel = 1; run_seq(5 + int'($urandom_range(60)), 0);
    sel = 0; run_seq(10, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule